// File: doc/BRIEF.md
# SPI Slave-Select and Mode-Fault Controller

This block decides what the slave-select pin of an SPI peripheral does and guards the bus against two masters driving it at once. The peripheral can act as master or as slave. The block does not shift data, generate baud rates or talk to a CPU bus. It receives the slave-select pin level, the configured role, a mode-fault enable, the shared port's direction bit and output value, the serial clock, and a flag-clear strobe. It returns the pin direction and drive value, the enables for MISO, MOSI and the serial clock, a gated serial clock for the slave shifter, a transfer-abort pulse and a sticky mode-fault flag.

Two flip-flops synchronize slave-select before any other logic uses it. As a slave, a deselected peripheral releases MISO and passes no clock edges to its shifter. A rising select line aborts any byte in progress. As a master with fault detection enabled, a low select line means another master has claimed the bus. The block then sets the fault flag, removes its own MOSI and clock drive in that same cycle, and falls back to slave behaviour until software clears the flag. With fault detection disabled, a master leaves the pin to the general-purpose port.

Top module: `spi_ss_ctrl`

## Requirements
- R1: When the effective role is slave, `ss_oe_o` is 0, whatever the values of `flt_en_i` and `ddr_i`.
- R2: As a slave with synchronized SS high, `miso_oe_o` and `sck_gate_o` are 0. As a slave with synchronized SS low, `miso_oe_o` is 1 and `sck_gate_o` equals `sck_i`.
- R3: The pin is synchronized through two flops. When the pin rises with the effective role slave, `abort_o` is high for exactly one cycle, visible after the second rising clock edge that follows the pin change.
- R4: A slave-side rising SS sets `fault_o` at the next edge only when `flt_en_i` is 1. With `flt_en_i` at 0 the abort still occurs but `fault_o` stays 0.
- R5: As master with `flt_en_i`=0, `ss_oe_o` equals `ddr_i`. `ss_out_o` equals `port_out_i` while driving and is 0 otherwise.
- R6: As master with `flt_en_i`=1, `ss_oe_o` is 0 for either value of `ddr_i`.
- R7: As master with `flt_en_i`=1 and synchronized SS low, `mosi_oe_o`, `sck_oe_o` and `master_o` go to 0 in that same cycle, and `fault_o` is 1 from the next edge.
- R8: `fault_o` stays 1 until a cycle with `flt_clr_i`=1. A set condition in the same cycle as a clear keeps it at 1.
- R9: `ss_raw_o` always equals `ss_pin_i`, in every role.
- R10: While `fault_o` is 1 the effective role is slave (`master_o`=0). As master with no fault, `mosi_oe_o` and `sck_oe_o` are 1. After reset `fault_o` and `abort_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ss_pin_i | input | 1 | Slave-select pin level |
| mstr_cfg_i | input | 1 | Configured role, 1 = master |
| flt_en_i | input | 1 | Mode-fault detection enable |
| ddr_i | input | 1 | Shared port direction bit, 1 = output |
| port_out_i | input | 1 | Shared port output value |
| sck_i | input | 1 | Serial clock seen at the pin |
| flt_clr_i | input | 1 | Clear strobe for the fault flag |
| ss_oe_o | output | 1 | Slave-select pin output enable |
| ss_out_o | output | 1 | Slave-select pin drive value |
| ss_raw_o | output | 1 | Unsynchronized pin level for the port data path |
| miso_oe_o | output | 1 | MISO output enable |
| sck_gate_o | output | 1 | Serial clock passed to the slave shifter |
| abort_o | output | 1 | One-cycle slave transfer abort |
| fault_o | output | 1 | Sticky mode-fault flag |
| mosi_oe_o | output | 1 | MOSI output enable |
| sck_oe_o | output | 1 | Serial clock output enable |
| master_o | output | 1 | Effective role, 1 = master |

## Verification
The assertions check the pin-ownership rules on every cycle: a slave or fault-enabled master never drives the pin, and a deselected slave never enables MISO or the clock gate. They also check that the fault flag holds, that output drive is removed whenever a fault stands, and that an abort lasts one cycle. Only the bench scenarios can show the latency of the two-flop synchronizer, the exact edge at which the abort appears, that the abort raises the fault only when enabled, and the full sweep of role, enable, direction, port value and pin level against computed outputs.

// File: rtl/spi_ss_pkg.sv
package spi_ss_pkg;
  typedef enum logic {
    ROLE_SLAVE  = 1'b0,
    ROLE_MASTER = 1'b1
  } role_e;

  localparam int unsigned SYNC_MIN_STAGES = 2;
  localparam logic SS_IDLE_LEVEL = 1'b1;
endpackage

// File: rtl/spi_ss_sync.sv
module spi_ss_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/spi_ss_edge.sv
module spi_ss_edge #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = lvl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= prev_d;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/spi_ss_fault.sv
module spi_ss_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/spi_ss_pinmux.sv
module spi_ss_pinmux
  import spi_ss_pkg::*;
(
  input  role_e role_i,
  input  logic  flt_en_i,
  input  logic  ddr_i,
  input  logic  port_out_i,
  input  logic  ss_sync_i,
  input  logic  sck_i,
  output logic  ss_oe_o,
  output logic  ss_out_o,
  output logic  miso_oe_o,
  output logic  sck_gate_o,
  output logic  mosi_oe_o,
  output logic  sck_oe_o
);
  logic is_master;
  logic slave_sel;

  always_comb begin
    is_master  = (role_i == ROLE_MASTER);
    slave_sel  = ~is_master & ~ss_sync_i;
    ss_oe_o    = is_master & ~flt_en_i & ddr_i;
    ss_out_o   = ss_oe_o & port_out_i;
    miso_oe_o  = slave_sel;
    sck_gate_o = slave_sel & sck_i;
    mosi_oe_o  = is_master;
    sck_oe_o   = is_master;
  end
endmodule

// File: rtl/spi_ss_ctrl.sv
module spi_ss_ctrl
  import spi_ss_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ss_pin_i,
  input  logic mstr_cfg_i,
  input  logic flt_en_i,
  input  logic ddr_i,
  input  logic port_out_i,
  input  logic sck_i,
  input  logic flt_clr_i,
  output logic ss_oe_o,
  output logic ss_out_o,
  output logic ss_raw_o,
  output logic miso_oe_o,
  output logic sck_gate_o,
  output logic abort_o,
  output logic fault_o,
  output logic mosi_oe_o,
  output logic sck_oe_o,
  output logic master_o
);
  localparam int unsigned STAGES_EFF =
    (SYNC_STAGES < SYNC_MIN_STAGES) ? SYNC_MIN_STAGES : SYNC_STAGES;

  logic  ss_sync;
  logic  ss_rise;
  logic  fault_q;
  logic  mstr_pre;
  logic  mstr_flt_set;
  logic  slv_flt_set;
  role_e role_eff;

  spi_ss_sync #(.STAGES(STAGES_EFF), .RST_VAL(SS_IDLE_LEVEL)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ss_pin_i),
    .dout (ss_sync)
  );

  spi_ss_edge #(.RST_VAL(SS_IDLE_LEVEL)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (ss_sync),
    .rise_o(ss_rise)
  );

  always_comb begin
    mstr_pre     = mstr_cfg_i & ~fault_q;
    mstr_flt_set = mstr_pre & flt_en_i & ~ss_sync;
    slv_flt_set  = ~mstr_pre & flt_en_i & ss_rise;
    role_eff     = (mstr_pre & ~mstr_flt_set) ? ROLE_MASTER : ROLE_SLAVE;
  end

  spi_ss_fault u_fault (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (mstr_flt_set | slv_flt_set),
    .clr_i (flt_clr_i),
    .flag_o(fault_q)
  );

  spi_ss_pinmux u_mux (
    .role_i    (role_eff),
    .flt_en_i  (flt_en_i),
    .ddr_i     (ddr_i),
    .port_out_i(port_out_i),
    .ss_sync_i (ss_sync),
    .sck_i     (sck_i),
    .ss_oe_o   (ss_oe_o),
    .ss_out_o  (ss_out_o),
    .miso_oe_o (miso_oe_o),
    .sck_gate_o(sck_gate_o),
    .mosi_oe_o (mosi_oe_o),
    .sck_oe_o  (sck_oe_o)
  );

  assign ss_raw_o = ss_pin_i;
  assign abort_o  = ~mstr_pre & ss_rise;
  assign fault_o  = fault_q;
  assign master_o = (role_eff == ROLE_MASTER);
endmodule

// File: rtl/spi_ss_ctrl_chk.sv
module spi_ss_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ss_sync,
  input logic ss_pin_i,
  input logic flt_en_i,
  input logic flt_clr_i,
  input logic ss_oe_o,
  input logic ss_raw_o,
  input logic miso_oe_o,
  input logic sck_gate_o,
  input logic abort_o,
  input logic fault_o,
  input logic mosi_oe_o,
  input logic sck_oe_o,
  input logic master_o
);
  // R1
  a_r1_slave_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !master_o |-> !ss_oe_o);
  // R2
  a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_o && ss_sync) |-> (!miso_oe_o && !sck_gate_o));
  // R3
  a_r3_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !abort_o);
  // R6
  a_r6_enabled_master_input: assert property (@(posedge clk) disable iff (!rst_n)
    (master_o && flt_en_i) |-> !ss_oe_o);
  // R7
  a_r7_master_yields: assert property (@(posedge clk) disable iff (!rst_n)
    (master_o && flt_en_i) |-> ss_sync);
  // R8
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && !flt_clr_i) |=> fault_o);
  // R9
  a_r9_raw_level: assert property (@(posedge clk) disable iff (!rst_n)
    ss_raw_o == ss_pin_i);
  // R10
  a_r10_fault_releases: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (!master_o && !mosi_oe_o && !sck_oe_o));
endmodule

bind spi_ss_ctrl spi_ss_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ss_sync   (ss_sync),
  .ss_pin_i  (ss_pin_i),
  .flt_en_i  (flt_en_i),
  .flt_clr_i (flt_clr_i),
  .ss_oe_o   (ss_oe_o),
  .ss_raw_o  (ss_raw_o),
  .miso_oe_o (miso_oe_o),
  .sck_gate_o(sck_gate_o),
  .abort_o   (abort_o),
  .fault_o   (fault_o),
  .mosi_oe_o (mosi_oe_o),
  .sck_oe_o  (sck_oe_o),
  .master_o  (master_o)
);

// File: tb/spi_ss_ctrl_test.sv
`timescale 1ns/1ps
module spi_ss_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ss_pin = 1'b1, mstr = 1'b0, en = 1'b0, ddr = 1'b0, pout = 1'b0;
  logic sck = 1'b0, clr = 1'b0;
  logic ss_oe, ss_out, ss_raw, miso_oe, sck_gate, abort_s, fault;
  logic mosi_oe, sck_oe, master;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_ss_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ss_pin_i(ss_pin), .mstr_cfg_i(mstr),
    .flt_en_i(en), .ddr_i(ddr), .port_out_i(pout), .sck_i(sck),
    .flt_clr_i(clr), .ss_oe_o(ss_oe), .ss_out_o(ss_out), .ss_raw_o(ss_raw),
    .miso_oe_o(miso_oe), .sck_gate_o(sck_gate), .abort_o(abort_s),
    .fault_o(fault), .mosi_oe_o(mosi_oe), .sck_oe_o(sck_oe), .master_o(master)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic logic [15:0] outs();
    return {7'd0, ss_oe, ss_out, ss_raw, miso_oe, sck_gate, abort_s, fault,
            mosi_oe, sck_oe, master};
  endfunction

  initial begin
    cyc(3);
    #1;
    chk("R10 reset", {14'd0, fault, abort_s}, 16'd0);
    rst_n = 1'b1;
    cyc(2);

    // Sweep R1 R2 R5 R6 R7 R8 R9 R10 over role, enable, ddr, port value, pin
    for (int i = 0; i < 32; i++) begin
      logic m, e, d, p, s, f, me, soe;
      {m, e, d, p, s} = i[4:0];
      mstr = m; en = e; ddr = d; pout = p; ss_pin = s;
      cyc(4);
      clr = 1'b1;
      cyc(1);
      clr = 1'b0;
      cyc(2);
      #1;
      f   = m & e & ~s;
      me  = m & ~f;
      soe = me & ~e & d;
      chk("R1/R2/R5/R6/R7/R8/R9/R10 sweep", outs(),
          {7'd0, soe, soe & p, s, ~me & ~s, 1'b0, 1'b0, f, me, me, me});
    end

    // R2 slave selected: clock passes through gate
    mstr = 0; en = 0; ss_pin = 0; clr = 1;
    cyc(4);
    clr = 0;
    sck = 1;
    #1 chk("R2 gate follows sck high", {15'd0, sck_gate}, 16'd1);
    sck = 0;
    #1 chk("R2 gate follows sck low", {15'd0, sck_gate}, 16'd0);

    // R3 abort timing, R4 no fault with enable low
    @(negedge clk);
    ss_pin = 1;
    @(posedge clk); @(posedge clk); #1;
    chk("R3 abort after second edge", {15'd0, abort_s}, 16'd1);
    @(posedge clk); #1;
    chk("R3 abort one cycle", {15'd0, abort_s}, 16'd0);
    chk("R4 no fault when disabled", {15'd0, fault}, 16'd0);
    sck = 1;
    #1 chk("R2 deselected gate blocked", {14'd0, sck_gate, miso_oe}, 16'd0);
    sck = 0;

    // R4 fault with enable high, R8 sticky then clear
    @(negedge clk);
    en = 1; ss_pin = 0;
    cyc(4);
    ss_pin = 1;
    @(posedge clk); @(posedge clk); #1;
    chk("R3 abort enabled case", {15'd0, abort_s}, 16'd1);
    chk("R4 fault not yet", {15'd0, fault}, 16'd0);
    @(posedge clk); #1;
    chk("R4 fault set by slave abort", {15'd0, fault}, 16'd1);
    cyc(6);
    chk("R8 fault holds", {15'd0, fault}, 16'd1);
    clr = 1;
    cyc(1);
    clr = 0;
    #1 chk("R8 fault cleared", {15'd0, fault}, 16'd0);

    // R7 competing master: drive removed in the cycle before flag shows
    mstr = 1; en = 1; ss_pin = 1;
    cyc(4);
    #1 chk("R10 master drives", {14'd0, mosi_oe, sck_oe}, 16'd3);
    @(negedge clk);
    ss_pin = 0;
    @(posedge clk); @(posedge clk); #1;
    chk("R7 drive dropped same cycle", {13'd0, mosi_oe, sck_oe, master}, 16'd0);
    chk("R7 flag next edge pending", {15'd0, fault}, 16'd0);
    @(posedge clk); #1;
    chk("R7 flag set", {15'd0, fault}, 16'd1);
    ss_pin = 1;
    cyc(6);
    chk("R10 fault keeps slave role", {15'd0, master}, 16'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule